// File: doc/BRIEF.md
# Multiplexed Status Packet Reporter

This block reports per-channel status words to a downstream byte-serial status ring. Each channel offers four 26-bit status views: a local end-of-frame pointer, an acknowledged end-of-frame pointer, a local current pointer and an acknowledged current pointer. A configuration write picks one view per channel. A write to a channel's arm address queues one report for that channel and advances that channel's 6-bit sequence counter.

While a report is queued and no packet is being streamed, the block raises a request and presents an address byte that names the channel. When the downstream logic acknowledges that byte, the block captures the selected status word and the sequence number in a holding register. It then drives four more bytes, one per clock: the sequence number packed with the two low status bits, followed by the remaining status bits in groups of eight. Queued channels are served from the lowest index upward.

Top module: `stat_pkt_reporter`

## Requirements
- R1: Synchronous reset clears all queued reports, sets every channel's view to 0 and every sequence counter to 0. `pkt_req` and `pkt_byte` then read 0. Reset also discards a report that was queued before it.
- R2: A write to address 0 treats `cfg_wdata` as one 4-bit group per channel, with channel c in bits [4c+3:4c]. When bit 4c+2 is 1, the channel's view becomes bits [4c+1:4c]. When bit 4c+2 is 0, the channel's view is left unchanged. View 0 is the local end-of-frame pointer, 1 the acknowledged end-of-frame pointer, 2 the local current pointer and 3 the acknowledged current pointer. View v of channel c is `src_words[((c*4+v)*26) +: 26]`.
- R3: A write of any data to address 4+c queues a report for channel c. In the next cycle `pkt_req` is 1 and `pkt_byte` holds the address byte {`ADDR_TAG`[7:2], c[1:0]} (0xA0 | c by default).
- R4: Each arm write increments that channel's 6-bit sequence counter, which wraps from 63 to 0. A packet carries the counter value present in its acknowledge cycle.
- R5: An acknowledge while `pkt_req` is 1 accepts the address byte. The status word of the channel's current view and the sequence number are captured in that cycle. In the four following cycles `pkt_byte` carries {seq[5:0], st[1:0]}, st[9:2], st[17:10] and st[25:18]. A change of the source after the acknowledge does not alter these bytes.
- R6: When several channels are queued, the lowest-indexed one is offered first. After each packet, `pkt_req` rises again until no report is queued.
- R7: An acknowledge while `pkt_req` is 0 has no effect: no bytes are streamed, and a later arm raises `pkt_req` in the next cycle.
- R8: `pkt_req` is 0 while the four data bytes are streamed. An arm write made during streaming stays queued and is served afterwards.
- R9: Writes to addresses 1, 2 and 3 neither queue a report nor raise `pkt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (3) | Configuration address |
| cfg_wdata | input | 4*NCH (16) | Configuration write data |
| src_words | input | NCH*4*SW (416) | All status views of all channels, packed |
| pkt_req | output | 1 | A packet is ready to send |
| pkt_ack | input | 1 | Downstream accepts the address byte |
| pkt_byte | output | 8 | Packet byte stream |

## Verification
The assertions assume that `pkt_ack` is pulsed only while `pkt_req` is high or harmlessly otherwise, that `src_words` may change in any cycle, and that writes arrive as one-cycle strobes. The bench drives `pkt_ack` for exactly one cycle per packet. It deliberately pulses the acknowledge once while no request is raised, and it changes the source right after an acknowledge. Configuration writes are single-cycle strobes, including one issued while a packet is being streamed, so every input stays inside the stated assumptions.

// File: rtl/stat_pkt_pkg.sv
package stat_pkt_pkg;
  typedef enum logic [1:0] {
    VIEW_EOF_LOCAL = 2'd0,
    VIEW_EOF_ACKED = 2'd1,
    VIEW_CUR_LOCAL = 2'd2,
    VIEW_CUR_ACKED = 2'd3
  } view_e;

  localparam int BYTE_W  = 8;
  localparam int NVIEW   = 4;
  localparam int GRP_W   = 4;  // config bits per channel in the view word
  localparam int GRP_SET = 2;  // update-enable bit inside a group
endpackage

// File: rtl/stat_cfg_regs.sv
module stat_cfg_regs
  import stat_pkt_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 3,
  parameter int SEQW      = 6,
  parameter int MODE_ADDR = 0,
  parameter int ARM_BASE  = 4,
  localparam int MW       = GRP_W * NCH
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [MW-1:0]             wdata,
  output logic [NCH-1:0][1:0]       view,
  output logic [NCH-1:0]            arm,
  output logic [NCH-1:0][SEQW-1:0]  seq
);

  logic mode_hit;
  logic [NCH-1:0] spare;
  wire  unused_spare = ^spare;

  always_comb begin
    mode_hit = we && (int'(addr) == MODE_ADDR);
    for (int c = 0; c < NCH; c++) begin
      arm[c]   = we && (int'(addr) == ARM_BASE + c);
      spare[c] = wdata[c*GRP_W + 3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      view <= '0;
      seq  <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (mode_hit && wdata[c*GRP_W + GRP_SET]) view[c] <= wdata[c*GRP_W +: 2];
        if (arm[c]) seq[c] <= seq[c] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R2
    mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_hit && !wdata[g*GRP_W + GRP_SET]) |=> $stable(view[g]));
    // R4
    seq_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !arm[g] |=> $stable(seq[g]));
  end

endmodule

// File: rtl/stat_pend_sched.sv
module stat_pend_sched #(
  parameter int NCH  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] arm,
  input  logic           accept,
  output logic [NCH-1:0] pending,
  output logic [CHW-1:0] sel,
  output logic           any
);

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) sel = CHW'(i);
    end
    any = |pending;
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= (pending & ~(accept ? (NCH'(1) << sel) : NCH'(0))) | arm;
  end

  // R6
  pick_low_chk: assert property (@(posedge clk) disable iff (rst)
    any |-> (pending[sel] && ((pending & ((NCH'(1) << sel) - NCH'(1))) == '0)));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R8
    arm_keep_chk: assert property (@(posedge clk) disable iff (rst)
      arm[g] |=> pending[g]);
    // R6
    drop_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(pending[g]) |-> $past(accept && (sel == CHW'(g))));
  end

endmodule

// File: rtl/stat_pkt_ser.sv
module stat_pkt_ser
  import stat_pkt_pkg::*;
#(
  parameter int SW    = 26,
  parameter int SEQW  = 6,
  localparam int HW   = SW + SEQW,
  localparam int NBEAT = HW / BYTE_W,
  localparam int BW   = (NBEAT > 1) ? $clog2(NBEAT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [SW-1:0]     word,
  input  logic [SEQW-1:0]   seq,
  output logic              busy,
  output logic [BYTE_W-1:0] data_byte
);

  logic [HW-1:0] hold;
  logic [BW-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      busy <= 1'b0;
      beat <= '0;
    end else if (accept) begin
      hold <= {word[SW-1:2], seq, word[1:0]};
      busy <= 1'b1;
      beat <= '0;
    end else if (busy) begin
      if (beat == BW'(NBEAT - 1)) busy <= 1'b0;
      else                        beat <= beat + 1'b1;
    end
  end

  assign data_byte = hold[int'(beat)*BYTE_W +: BYTE_W];

  // R5
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(accept));
  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(hold));
  // R8
  accept_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);

endmodule

// File: rtl/stat_pkt_reporter.sv
module stat_pkt_reporter
  import stat_pkt_pkg::*;
#(
  parameter int NCH             = 4,
  parameter int SW              = 26,
  parameter int SEQW            = 6,
  parameter int AW              = 3,
  parameter int MODE_ADDR       = 0,
  parameter int ARM_BASE        = 4,
  parameter logic [7:0] ADDR_TAG = 8'hA0,
  localparam int CHW            = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MW             = GRP_W * NCH,
  localparam int SRCW           = NCH * NVIEW * SW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [MW-1:0]     cfg_wdata,
  input  logic [SRCW-1:0]   src_words,
  output logic              pkt_req,
  input  logic              pkt_ack,
  output logic [BYTE_W-1:0] pkt_byte
);

  logic [NCH-1:0][1:0]      view;
  logic [NCH-1:0]           arm;
  logic [NCH-1:0][SEQW-1:0] seq;
  logic [NCH-1:0]           pending;
  logic [CHW-1:0]           sel;
  logic                     any;
  logic                     busy;
  logic                     accept;
  logic [BYTE_W-1:0]        data_byte;
  view_e                    sel_view;
  logic [SW-1:0]            sel_word;

  stat_cfg_regs #(
    .NCH(NCH), .AW(AW), .SEQW(SEQW), .MODE_ADDR(MODE_ADDR), .ARM_BASE(ARM_BASE)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .view(view), .arm(arm), .seq(seq)
  );

  stat_pend_sched #(.NCH(NCH)) u_sched (
    .clk(clk), .rst(rst), .arm(arm), .accept(accept),
    .pending(pending), .sel(sel), .any(any)
  );

  always_comb begin
    sel_view = view_e'(view[sel]);
    sel_word = src_words[(int'(sel)*NVIEW + int'(sel_view))*SW +: SW];
  end

  stat_pkt_ser #(.SW(SW), .SEQW(SEQW)) u_ser (
    .clk(clk), .rst(rst), .accept(accept), .word(sel_word), .seq(seq[sel]),
    .busy(busy), .data_byte(data_byte)
  );

  assign pkt_req  = any && !busy;
  assign accept   = pkt_req && pkt_ack;
  assign pkt_byte = busy ? data_byte : (any ? {ADDR_TAG[7:CHW], sel} : '0);

  // R7
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!pkt_req && !busy && pkt_ack) |=> !busy);
  // R3
  arm_req_chk: assert property (@(posedge clk) disable iff (rst)
    (|arm) |=> (pkt_req || busy));

endmodule

// File: tb/stat_pkt_reporter_bench.sv
`timescale 1ns/1ps
module stat_pkt_reporter_bench;
  localparam int NCH = 4, NV = 4, SW = 26, SEQW = 6, AW = 3, MW = 16;
  localparam logic [7:0] TAG = 8'hA0;

  logic clk = 1'b0, rst = 1'b1, cfg_we = 1'b0, pkt_ack = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [MW-1:0] cfg_wdata = '0;
  logic [NCH*NV*SW-1:0] src = '0;
  wire pkt_req;
  wire [7:0] pkt_byte;

  always #5 clk = ~clk;

  stat_pkt_reporter u_stat_pkt_reporter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .src_words(src), .pkt_req(pkt_req), .pkt_ack(pkt_ack), .pkt_byte(pkt_byte)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int m_mode[NCH];
  int m_seq[NCH];
  bit m_pend[NCH];
  logic [7:0] exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_src(input int c, input int m, input int k);
    logic [31:0] v;
    v = 32'h0135_79BD * (c*NV + m + 1) + k * 32'h0001_3579;
    src[(c*NV + m)*SW +: SW] = v[SW-1:0];
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      m_mode[c] = 0; m_seq[c] = 0; m_pend[c] = 0;
    end
  endtask

  function automatic int low_pend();
    for (int c = 0; c < NCH; c++) if (m_pend[c]) return c;
    return -1;
  endfunction

  task automatic model_write(input int a, input logic [MW-1:0] d);
    if (a == 0) begin
      for (int c = 0; c < NCH; c++) if (d[c*4+2]) m_mode[c] = int'(d[c*4 +: 2]);
    end else if (a >= 4 && a < 4 + NCH) begin
      m_pend[a-4] = 1;
      m_seq[a-4] = (m_seq[a-4] + 1) % 64;
    end
  endtask

  task automatic wr(input int a, input logic [MW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    model_write(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: pushes the expected packet, then acknowledges it
  task automatic serve(input string tag, input int arm_ch, input bit bump);
    int c;
    logic [SW-1:0] st;
    logic [31:0] hold;
    logic [7:0] ab;
    @(negedge clk);
    c = low_pend();
    check(pkt_req === 1'b1, {tag, " R6 request before packet"}, int'(pkt_req), 1);
    if (c < 0) c = 0;
    ab = {TAG[7:2], 2'(c)};
    check(pkt_byte === ab, {tag, " R3/R6 address byte"}, int'(pkt_byte), int'(ab));
    st = src[(c*NV + m_mode[c])*SW +: SW];
    hold = {st[SW-1:2], 6'(m_seq[c]), st[1:0]};
    exp_q.push_back(ab); tag_q.push_back({tag, " R3 addr"});
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(hold[k*8 +: 8]); tag_q.push_back({tag, " R5 data"});
    end
    pkt_ack = 1'b1;
    m_pend[c] = 0;
    @(negedge clk);
    pkt_ack = 1'b0;
    check(pkt_req === 1'b0, {tag, " R8 request low while streaming"}, int'(pkt_req), 0);
    if (bump) set_src(c, m_mode[c], 99);
    if (arm_ch >= 0) begin
      cfg_we = 1'b1; cfg_addr = AW'(4 + arm_ch); cfg_wdata = '0;
      model_write(4 + arm_ch, '0);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    check(pkt_req === (low_pend() >= 0), {tag, " R6 request after packet"},
          int'(pkt_req), int'(low_pend() >= 0));
  endtask

  // monitor: pops expected bytes as the design produces them
  initial begin
    int left;
    logic [7:0] e;
    string t;
    left = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst) left = 0;
      else if (left > 0 || (pkt_req && pkt_ack)) begin
        if (exp_q.size() == 0) check(1'b0, "scoreboard empty", int'(pkt_byte), 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(pkt_byte === e, t, int'(pkt_byte), int'(e));
        end
        left = (left > 0) ? left - 1 : 4;
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    model_clear();
    for (int c = 0; c < NCH; c++) for (int m = 0; m < NV; m++) set_src(c, m, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pkt_req === 1'b0, "R1 reset request", int'(pkt_req), 0);
    check(pkt_byte === 8'h00, "R1 reset byte", int'(pkt_byte), 0);

    // R9 unmapped writes; R2 view write with no set bits
    wr(1, '1); wr(2, '1); wr(3, '1);
    check(pkt_req === 1'b0, "R9 unmapped write request", int'(pkt_req), 0);
    check(pkt_byte === 8'h00, "R9 unmapped write byte", int'(pkt_byte), 0);
    wr(0, 16'h3333);

    // R7 acknowledge without request
    @(negedge clk); pkt_ack = 1'b1;
    @(negedge clk); pkt_ack = 1'b0;
    check(pkt_req === 1'b0, "R7 stray ack request", int'(pkt_req), 0);
    wr(4, '0);
    check(pkt_req === 1'b1, "R7/R3 request right after arm", int'(pkt_req), 1);
    serve("R1 default view and first sequence", -1, 0);

    // R2 selective view update, R6 ordering
    wr(0, 16'h6371);
    wr(7, '0); wr(5, '0); wr(4, '0);
    serve("R6 first", -1, 0);
    serve("R6 second", -1, 0);
    serve("R2 R6 third", -1, 0);

    // R4 increments and wrap
    wr(5, '0); wr(5, '0); wr(5, '0);
    serve("R4 step", -1, 0);
    for (int i = 0; i < 64; i++) wr(6, '0);
    serve("R4 wrap", -1, 0);

    // R5 capture at acknowledge
    wr(7, '0);
    serve("R5 coherent", -1, 1);

    // R8 arm during streaming
    wr(5, '0);
    serve("R8 stream with arm", 0, 0);
    serve("R8 late arm served", -1, 0);

    // R1 reset drops a queued report
    wr(6, '0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_clear();
    @(negedge clk);
    check(pkt_req === 1'b0, "R1 reset clears queue", int'(pkt_req), 0);
    wr(5, '0);
    serve("R1 view and sequence after reset", -1, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule